// File: doc/BRIEF.md
# Pointer Register Address Generator

This block forms data-space addresses for indirect loads and stores. It holds the three 16-bit data pointers X, Y and Z and the stack pointer. When the strobe marks a decoded instruction word, the block reports four things combinationally: the effective address, whether the access writes, the 5-bit register operand, and whether the address lies past the end of the data space. It also presents a pointer write-back for any form that moves a pointer, and the pointer takes that value at the next clock edge.

A separate load path lets the register file overwrite any of the four pointers, for example after a constant is loaded into a pointer pair. Plain, post-increment, pre-decrement, displacement and stack forms are covered. The memory array and program-memory constant reads are outside this block.

Top module: `ptr_addr_gen`

## Requirements
- R1: With `strobe` high, a word of the form `1001 00sd dddd mmmm` is an indirect access. s (bit 9) = 1 is a store and sets `acc_write`. `acc_reg` = bits 8..4.
- R2: Post-increment modes are mmmm = 0001 (Z), 1001 (Y) and 1101 (X). The address is the old pointer, and the pointer becomes old+1.
- R3: Pre-decrement modes are mmmm = 0010 (Z), 1010 (Y) and 1110 (X). The pointer becomes old−1, and that new value is the address.
- R4: mmmm = 1100 addresses through X unchanged, with no write-back.
- R5: The displacement form is `10q0 qqsd dddd bqqq`, with q = {bit13, bits 11..10, bits 2..0} unsigned. b = 1 selects Y and b = 0 selects Z. The address is pointer + q, wrapping at 16 bits, and the pointer is left unchanged. q = 0 gives the plain access.
- R6: mmmm = 1111 is the stack form. A load (pop) reads at SP+1 and SP becomes SP+1. A store (push) writes at SP and SP becomes SP−1.
- R7: `acc_oor` is high for a valid access whose address exceeds 0x08FF.
- R8: After reset X = Y = Z = 0 and SP = 0x08FF.
- R9: With `strobe` low, or for any other word (including modes 0000, 0011, 0100–0111, 1000, 1011), `acc_valid` and `wb_valid` are low and no pointer changes.
- R10: `ld_en` writes `ld_data` into the pointer named by `ld_sel` (0 X, 1 Y, 2 Z, 3 SP). If it targets the pointer being written back in the same cycle, the load wins. The address still uses the value from before the load.
- R11: Pointer arithmetic wraps modulo 2^16. X = 0 pre-decremented gives address 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr | input | 16 | Decoded instruction word |
| strobe | input | 1 | Instruction word is valid this cycle |
| ld_en | input | 1 | Pointer load request |
| ld_sel | input | 2 | Pointer to load (0 X, 1 Y, 2 Z, 3 SP) |
| ld_data | input | 16 | Value to load |
| acc_valid | output | 1 | An indirect access is presented |
| acc_addr | output | 16 | Effective data-space address |
| acc_write | output | 1 | 1 store, 0 load |
| acc_reg | output | 5 | Register operand index |
| acc_oor | output | 1 | Address above 0x08FF |
| wb_valid | output | 1 | Pointer write-back present |
| wb_sel | output | 2 | Pointer being written back |
| wb_data | output | 16 | New pointer value |

## Verification
A pointer load and an auto-modifying access can land in the same cycle. The randomized stream sometimes loads the very pointer that the current access steps, and sometimes a different one. The bench model applies the load after the write-back, so the load wins on a collision while the other pointer still steps. The result shows up on a later access that exposes that pointer through its address. A directed case does this on the stack pointer during a push.

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen #(
  parameter int AW = 16,
  parameter logic [AW-1:0] DATA_TOP = 16'h08FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   instr,
  input  logic          strobe,
  input  logic          ld_en,
  input  logic [1:0]    ld_sel,
  input  logic [AW-1:0] ld_data,
  output logic          acc_valid,
  output logic [AW-1:0] acc_addr,
  output logic          acc_write,
  output logic [4:0]    acc_reg,
  output logic          acc_oor,
  output logic          wb_valid,
  output logic [1:0]    wb_sel,
  output logic [AW-1:0] wb_data
);
  localparam logic [1:0] SEL_X = 2'd0, SEL_Y = 2'd1, SEL_Z = 2'd2, SEL_SP = 2'd3;
  localparam logic [AW-1:0] SP_INIT = DATA_TOP;

  typedef enum logic [2:0] {ST_NONE, ST_POST_INC, ST_PRE_DEC, ST_PRE_INC, ST_POST_DEC} step_e;

  logic [AW-1:0] ptr_q [4];
  logic [1:0]    sel;
  step_e         step;
  logic          known;
  logic [AW-1:0] base, plus1, minus1;

  wire       is_ind  = instr[15:10] == 6'b100100;
  wire       is_disp = instr[15:14] == 2'b10 && !instr[12];
  wire [3:0] mode    = instr[3:0];
  wire [5:0] q       = {instr[13], instr[11:10], instr[2:0]};

  always_comb begin
    sel   = SEL_X;
    step  = ST_NONE;
    known = 1'b0;
    if (is_disp) begin
      known = 1'b1;
      sel   = instr[3] ? SEL_Y : SEL_Z;
    end else if (is_ind) begin
      known = 1'b1;
      case (mode)
        4'b0001: begin sel = SEL_Z;  step = ST_POST_INC; end
        4'b0010: begin sel = SEL_Z;  step = ST_PRE_DEC;  end
        4'b1001: begin sel = SEL_Y;  step = ST_POST_INC; end
        4'b1010: begin sel = SEL_Y;  step = ST_PRE_DEC;  end
        4'b1100: begin sel = SEL_X;  step = ST_NONE;     end
        4'b1101: begin sel = SEL_X;  step = ST_POST_INC; end
        4'b1110: begin sel = SEL_X;  step = ST_PRE_DEC;  end
        4'b1111: begin sel = SEL_SP; step = instr[9] ? ST_POST_DEC : ST_PRE_INC; end
        default: known = 1'b0;
      endcase
    end
  end

  assign base   = ptr_q[sel];
  assign plus1  = base + AW'(1);
  assign minus1 = base - AW'(1);

  always_comb begin
    case (step)
      ST_POST_INC: begin acc_addr = base;   wb_data = plus1;  end
      ST_PRE_DEC:  begin acc_addr = minus1; wb_data = minus1; end
      ST_PRE_INC:  begin acc_addr = plus1;  wb_data = plus1;  end
      ST_POST_DEC: begin acc_addr = base;   wb_data = minus1; end
      default:     begin acc_addr = base + (is_disp ? AW'(q) : AW'(0)); wb_data = base; end
    endcase
  end

  assign acc_valid = strobe && known;
  assign acc_write = instr[9];
  assign acc_reg   = instr[8:4];
  assign acc_oor   = acc_valid && (acc_addr > DATA_TOP);
  assign wb_valid  = acc_valid && (step != ST_NONE);
  assign wb_sel    = sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q[SEL_X]  <= '0;
      ptr_q[SEL_Y]  <= '0;
      ptr_q[SEL_Z]  <= '0;
      ptr_q[SEL_SP] <= SP_INIT;
    end else begin
      for (int i = 0; i < 4; i++) begin
        if (ld_en && ld_sel == 2'(i))        ptr_q[i] <= ld_data;
        else if (wb_valid && wb_sel == 2'(i)) ptr_q[i] <= wb_data;
      end
    end
  end

  p_wb_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !(ld_en && ld_sel == wb_sel) |=> ptr_q[$past(wb_sel)] == $past(wb_data));

  p_step_unit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_data == acc_addr || wb_data == acc_addr + AW'(1) || wb_data + AW'(1) == acc_addr));

  p_disp_no_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && is_disp |-> acc_valid && !wb_valid);

  p_oor_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_oor |-> acc_valid);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_valid && !ld_en |=> $stable(ptr_q[0]) && $stable(ptr_q[1]) && $stable(ptr_q[2]) && $stable(ptr_q[3]));

  p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> ptr_q[$past(ld_sel)] == $past(ld_data));
endmodule

// File: tb/ptr_addr_gen_tb.sv
`timescale 1ns/1ps
module ptr_addr_gen_tb_top;
  logic clk = 0, rst_n = 0;
  logic [15:0] instr = 0, ld_data = 0;
  logic strobe = 0, ld_en = 0;
  logic [1:0] ld_sel = 0;
  logic acc_valid, acc_write, acc_oor, wb_valid;
  logic [15:0] acc_addr, wb_data;
  logic [4:0] acc_reg;
  logic [1:0] wb_sel;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] m [4];

  always #5 clk = ~clk;

  ptr_addr_gen dut_i (.clk(clk), .rst_n(rst_n), .instr(instr), .strobe(strobe),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_write(acc_write), .acc_reg(acc_reg), .acc_oor(acc_oor),
    .wb_valid(wb_valid), .wb_sel(wb_sel), .wb_data(wb_data));

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // stp: 0 none, 1 post-inc, 2 pre-dec, 3 pre-inc, 4 post-dec
  task automatic op(logic [15:0] ins, bit stb, bit ok, logic [1:0] sel, int stp, bit isd,
                    logic [5:0] q, bit ld, logic [1:0] lsel, logic [15:0] ldat, string rq);
    logic [15:0] b, a, w;
    bit ev, wv;
    @(negedge clk);
    instr = ins; strobe = stb; ld_en = ld; ld_sel = lsel; ld_data = ldat;
    b = m[sel]; ev = stb && ok; wv = ev && (stp != 0);
    case (stp)
      1: begin a = b; w = b + 16'd1; end
      2: begin a = b - 16'd1; w = a; end
      3: begin a = b + 16'd1; w = a; end
      4: begin a = b; w = b - 16'd1; end
      default: begin a = b + (isd ? {10'd0, q} : 16'd0); w = b; end
    endcase
    #2;
    chk({rq, " valid"}, acc_valid, ev);
    if (ev) begin
      chk({rq, " addr"}, acc_addr, a);
      chk({rq, " write R1"}, acc_write, ins[9]);
      chk({rq, " reg R1"}, acc_reg, ins[8:4]);
      chk({rq, " oor R7"}, acc_oor, a > 16'h08FF);
      chk({rq, " wb_valid"}, wb_valid, wv);
      if (wv) begin
        chk({rq, " wb_sel"}, wb_sel, sel);
        chk({rq, " wb_data"}, wb_data, w);
      end
    end else chk({rq, " wb_valid idle R9"}, wb_valid, 0);
    @(posedge clk); #1;
    if (wv) m[sel] = w;
    if (ld) m[lsel] = ldat;
    strobe = 0; ld_en = 0;
  endtask

  task automatic ind(bit st, logic [4:0] r, logic [3:0] md, bit stb, bit ld,
                     logic [1:0] lsel, logic [15:0] ldat, string rq);
    bit ok = 1; logic [1:0] sel = 0; int stp = 0;
    case (md)
      4'd1:  begin sel = 2; stp = 1; end
      4'd2:  begin sel = 2; stp = 2; end
      4'd9:  begin sel = 1; stp = 1; end
      4'd10: begin sel = 1; stp = 2; end
      4'd12: begin sel = 0; stp = 0; end
      4'd13: begin sel = 0; stp = 1; end
      4'd14: begin sel = 0; stp = 2; end
      4'd15: begin sel = 3; stp = st ? 4 : 3; end
      default: ok = 0;
    endcase
    op({6'b100100, st, r, md}, stb, ok, sel, stp, 0, 6'd0, ld, lsel, ldat, rq);
  endtask

  task automatic dsp(bit st, logic [4:0] r, bit by, logic [5:0] q, bit ld,
                     logic [1:0] lsel, logic [15:0] ldat, string rq);
    op({2'b10, q[5], 1'b0, q[4:3], st, r, by, q[2:0]}, 1, 1, by ? 2'd1 : 2'd2, 0, 1, q,
       ld, lsel, ldat, rq);
  endtask

  task automatic setp(logic [1:0] s, logic [15:0] v);
    op(16'h0000, 0, 0, 0, 0, 0, 6'd0, 1, s, v, "R10 load");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] vmodes [8] = '{4'd1, 4'd2, 4'd9, 4'd10, 4'd12, 4'd13, 4'd14, 4'd15};
    logic [3:0] bad [8] = '{4'd0, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd11};
    void'($urandom(32'd1234));
    m[0] = 0; m[1] = 0; m[2] = 0; m[3] = 16'h08FF;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R8 reset values seen through addresses
    ind(0, 5'd3, 4'd12, 1, 0, 0, 0, "R8 X reset R4");
    dsp(0, 5'd4, 1, 6'd0, 0, 0, 0, "R8 Y reset R5");
    dsp(1, 5'd4, 0, 6'd0, 0, 0, 0, "R8 Z reset R5");
    ind(1, 5'd7, 4'd15, 1, 0, 0, 0, "R8 SP reset R6 push");
    ind(0, 5'd7, 4'd15, 1, 0, 0, 0, "R6 pop");
    // R11 wrap and R7 range
    ind(0, 5'd1, 4'd14, 1, 0, 0, 0, "R11 X predec wrap");
    ind(1, 5'd1, 4'd13, 1, 0, 0, 0, "R11 X postinc wrap");
    setp(1, 16'h08FF);
    ind(0, 5'd2, 4'd9, 1, 0, 0, 0, "R7 Y at top R2");
    ind(0, 5'd2, 4'd12, 1, 0, 0, 0, "R7 X in range");
    dsp(0, 5'd9, 1, 6'd63, 0, 0, 0, "R5 max q R7");
    setp(2, 16'h0120);
    dsp(1, 5'd9, 0, 6'b101101, 0, 0, 0, "R5 scattered q");
    ind(0, 5'd9, 4'd2, 1, 0, 0, 0, "R3 Z predec");
    // R9 ignored words, then observe Z
    ind(0, 5'd9, 4'd1, 0, 0, 0, 0, "R9 strobe low");
    ind(0, 5'd9, 4'd5, 1, 0, 0, 0, "R9 bad mode");
    op(16'h0000, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R9 other word");
    dsp(0, 5'd9, 0, 6'd0, 0, 0, 0, "R9 Z unchanged");
    // R10 collision on SP during push, then observe
    ind(1, 5'd5, 4'd15, 1, 1, 3, 16'h0400, "R10 push with SP load");
    ind(1, 5'd5, 4'd15, 1, 0, 0, 0, "R10 SP shows load");
    ind(1, 5'd5, 4'd13, 1, 1, 1, 16'h0200, "R10 other pointer R2");
    dsp(0, 5'd5, 1, 6'd0, 0, 0, 0, "R10 Y loaded");
    ind(0, 5'd5, 4'd12, 1, 0, 0, 0, "R10 X stepped");
    for (int i = 0; i < 3000; i++) begin
      int k = $urandom % 6;
      bit ld = ($urandom % 4) == 0;
      logic [1:0] ls = 2'($urandom);
      logic [15:0] lv = ($urandom % 2) ? 16'($urandom % 16'h0A00) : 16'($urandom);
      logic [4:0] r = 5'($urandom);
      bit st = 1'($urandom);
      if (k <= 2) ind(st, r, vmodes[$urandom % 8], ($urandom % 8) != 0, ld, ls, lv, "R2 R3 R4 R6 rand");
      else if (k == 3) dsp(st, r, 1'($urandom), 6'($urandom), ld, ls, lv, "R5 rand");
      else if (k == 4) ind(st, r, bad[$urandom % 8], 1, ld, ls, lv, "R9 rand");
      else setp(ls, lv);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule